// File: doc/BRIEF.md
# Flow-Control Pause Receiver and Interval Timer

This block watches the receive byte stream of an Ethernet MAC for MAC Control pause frames. When a frame qualifies, it takes the 16-bit pause quanta from the frame and loads a down-counter. The counter is measured in slot times and steps on an external slot-time tick. While the count is non-zero, the block holds off the transmit MAC through `pause_hold`. The same condition is also visible as the `stat_active` status bit.

Qualification has two independent routes. The first route matches the reserved flow-control multicast destination. The second route accepts a unicast destination already matched upstream, either by the station perfect-match filter or by a pattern buffer. Reception is on when either a manual enable or an auto-negotiated enable is set. Dropping the manual enable cancels any running interval. A sticky received flag records each accepted frame, and a status-read strobe clears it.

Top module: `pause_rx_timer`

## Requirements
- R1: A frame is acted on only if `man_en` or `neg_en` is 1 in the cycle its last byte is presented. With both at 0, a frame leaves `pause_hold` and `stat_rcvd` unchanged.
- R2: When `man_en` goes from 1 to 0, `pause_hold` is 0 from the next clock edge, whatever count was running.
- R3: With `mcast_qual`=1, a frame qualifies when its bytes 0 to 5 are 01, 80, C2, 00, 00, 01 in that order. With both `mcast_qual` and `da_qual` at 0, no frame qualifies.
- R4: With `da_qual`=1, a frame qualifies when `sta_match` or `pat_match` is 1 in the cycle of its last byte.
- R5: The quanta is byte 16 (high) and byte 17 (low). If a frame's last byte is taken at edge n and the quanta is non-zero, `pause_hold` and `stat_active` read 1 after edge n+1.
- R6: Each cycle with `slot_tick`=1 decrements a non-zero count by one. `pause_hold` falls after exactly quanta ticks.
- R7: `stat_rcvd` is set one edge after a frame is accepted. It is cleared by a cycle with `stat_rd`=1. If a set and a read fall in the same cycle, the set wins.
- R8: A frame is a pause frame only if bytes 12 to 13 are 88, 08, bytes 14 to 15 are 00, 01, and it is at least 18 bytes long. A frame with `rx_err`=1 on its last byte is discarded.
- R9: A new accepted frame reloads the count with its quanta, even while an interval is running. A quanta of 0 drops `pause_hold` at once.
- R10: If a reload and a `slot_tick` fall in the same cycle, the count becomes the new quanta and is not decremented.
- R11: After reset, `pause_hold`, `stat_active` and `stat_rcvd` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received byte is present on `rx_data` |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | The present byte is byte 0 of a frame |
| rx_eof | input | 1 | The present byte is the last byte of a frame |
| rx_err | input | 1 | The frame ending on this byte is bad |
| sta_match | input | 1 | Destination matched the station perfect-match address |
| pat_match | input | 1 | Destination matched a pattern buffer |
| slot_tick | input | 1 | One slot time has elapsed |
| man_en | input | 1 | Manual pause reception enable |
| neg_en | input | 1 | Negotiated pause reception enable |
| mcast_qual | input | 1 | Qualify by the reserved multicast destination |
| da_qual | input | 1 | Qualify by upstream destination match |
| stat_rd | input | 1 | Status read strobe, clears `stat_rcvd` |
| pause_hold | output | 1 | Hold off the transmit MAC |
| stat_active | output | 1 | A pause interval is being timed |
| stat_rcvd | output | 1 | Sticky: a pause frame was accepted |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a counter reload and a slot tick. The second pair is setting the received flag and clearing it by a status read. The bench provokes both by raising `slot_tick` and `stat_rd` in the cycle between the frame's last byte and the counter load. It then checks that `stat_rcvd` stays 1. It also checks that the hold lasts exactly the new quanta of ticks, with no decrement taken on the load cycle.

// File: rtl/pause_pkg.sv
package pause_pkg;
  localparam int unsigned DA_BYTES  = 6;
  localparam int unsigned IDX_HDR   = 12;
  localparam int unsigned IDX_QHI   = 16;
  localparam int unsigned IDX_QLO   = 17;
  localparam int unsigned MIN_LAST  = IDX_QLO;
  localparam logic [47:0] PAUSE_MCAST = 48'h0180C2000001;
  localparam logic [31:0] PAUSE_HDR   = 32'h88080001;

  function automatic logic [7:0] mcast_byte(input int i);
    logic [47:0] sh;
    sh = PAUSE_MCAST >> (8 * (5 - i));
    return sh[7:0];
  endfunction

  function automatic logic [7:0] hdr_byte(input int i);
    logic [31:0] sh;
    sh = PAUSE_HDR >> (8 * (15 - i));
    return sh[7:0];
  endfunction
endpackage

// File: rtl/pause_frame_parser.sv
module pause_frame_parser
  import pause_pkg::*;
#(
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_sof,
  input  logic          rx_eof,
  input  logic          rx_err,
  input  logic          sta_match,
  input  logic          pat_match,
  input  logic          rx_enable,
  input  logic          mcast_qual,
  input  logic          da_qual,
  output logic          hit,
  output logic [QW-1:0] quanta
);
  localparam int CW = $clog2(MIN_LAST + 2);
  localparam logic [CW-1:0] SAT_IDX  = CW'(MIN_LAST + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(MIN_LAST);

  logic [CW-1:0] cnt_q, cnt_d, eidx;
  logic          mc_q, mc_d, hdr_q, hdr_d;
  logic [15:0]   qv_q, qv_d;
  logic          hit_q, hit_d;
  logic [QW-1:0] quanta_q, quanta_d;
  logic          qual;

  always_comb begin
    cnt_d = cnt_q;
    mc_d  = mc_q;
    hdr_d = hdr_q;
    qv_d  = qv_q;
    eidx  = rx_sof ? '0 : cnt_q;
    if (rx_valid) begin
      if (rx_sof) begin
        mc_d  = 1'b1;
        hdr_d = 1'b1;
      end
      if (int'(eidx) < DA_BYTES && rx_data != mcast_byte(int'(eidx)))
        mc_d = 1'b0;
      if (int'(eidx) >= IDX_HDR && int'(eidx) < IDX_QHI && rx_data != hdr_byte(int'(eidx)))
        hdr_d = 1'b0;
      if (int'(eidx) == IDX_QHI) qv_d[15:8] = rx_data;
      if (int'(eidx) == IDX_QLO) qv_d[7:0]  = rx_data;
      cnt_d = (eidx >= SAT_IDX) ? SAT_IDX : eidx + 1'b1;
    end
    qual  = (mcast_qual && mc_d) || (da_qual && (sta_match || pat_match));
    hit_d = rx_valid && rx_eof && !rx_err && (eidx >= LAST_IDX) && hdr_d && qual && rx_enable;
    quanta_d = hit_d ? qv_d[QW-1:0] : quanta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      mc_q     <= 1'b0;
      hdr_q    <= 1'b0;
      qv_q     <= '0;
      hit_q    <= 1'b0;
      quanta_q <= '0;
    end else begin
      cnt_q    <= cnt_d;
      mc_q     <= mc_d;
      hdr_q    <= hdr_d;
      qv_q     <= qv_d;
      hit_q    <= hit_d;
      quanta_q <= quanta_d;
    end
  end

  assign hit    = hit_q;
  assign quanta = quanta_q;
endmodule

// File: rtl/pause_interval_timer.sv
module pause_interval_timer #(
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [QW-1:0] load_val,
  input  logic          tick,
  input  logic          abort,
  output logic [QW-1:0] count,
  output logic          hold
);
  logic [QW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = abort || load || (tick && cnt_q != '0);
    cnt_d  = cnt_q;
    if (abort)     cnt_d = '0;
    else if (load) cnt_d = load_val;
    else if (tick && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
  assign hold  = (cnt_q != '0);
endmodule

// File: rtl/pause_status.sv
module pause_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic rcvd
);
  logic rcvd_q, rcvd_d;

  always_comb begin
    rcvd_d = rcvd_q;
    if (set)      rcvd_d = 1'b1;
    else if (clr) rcvd_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rcvd_q <= 1'b0;
    else        rcvd_q <= rcvd_d;
  end

  assign rcvd = rcvd_q;
endmodule

// File: rtl/pause_rx_timer.sv
module pause_rx_timer #(
  parameter int QW = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_sof,
  input  logic       rx_eof,
  input  logic       rx_err,
  input  logic       sta_match,
  input  logic       pat_match,
  input  logic       slot_tick,
  input  logic       man_en,
  input  logic       neg_en,
  input  logic       mcast_qual,
  input  logic       da_qual,
  input  logic       stat_rd,
  output logic       pause_hold,
  output logic       stat_active,
  output logic       stat_rcvd
);
  logic          man_q;
  logic          pause_abort;
  logic          frame_hit;
  logic [QW-1:0] frame_quanta;
  logic [QW-1:0] pause_count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) man_q <= 1'b0;
    else        man_q <= man_en;
  end

  assign pause_abort = man_q && !man_en;

  pause_frame_parser #(.QW(QW)) u_parser (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_err(rx_err),
    .sta_match(sta_match), .pat_match(pat_match),
    .rx_enable(man_en || neg_en),
    .mcast_qual(mcast_qual), .da_qual(da_qual),
    .hit(frame_hit), .quanta(frame_quanta)
  );

  pause_interval_timer #(.QW(QW)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .load(frame_hit), .load_val(frame_quanta),
    .tick(slot_tick), .abort(pause_abort),
    .count(pause_count), .hold(pause_hold)
  );

  pause_status u_status (
    .clk(clk), .rst_n(rst_n),
    .set(frame_hit), .clr(stat_rd), .rcvd(stat_rcvd)
  );

  assign stat_active = pause_hold;
endmodule

// File: rtl/pause_rx_timer_chk.sv
module pause_rx_timer_chk #(
  parameter int QW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          man_en,
  input logic          neg_en,
  input logic          slot_tick,
  input logic          stat_rd,
  input logic          pause_hold,
  input logic          stat_rcvd,
  input logic          frame_hit,
  input logic          pause_abort,
  input logic [QW-1:0] frame_quanta,
  input logic [QW-1:0] pause_count
);
  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  AST_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && frame_hit) |-> $past(man_en || neg_en)); // R1

  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(man_en) && !man_en) |=> !pause_hold); // R2

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_hit && !pause_abort) |=> (pause_count == frame_quanta)); // R9

  AST_TICK_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tick && !frame_hit && !pause_abort && pause_count != '0)
      |=> (pause_count == $past(pause_count) - QW'(1))); // R6

  AST_RCVD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_hit |=> stat_rcvd); // R7

  AST_RCVD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !frame_hit) |=> !stat_rcvd); // R7
endmodule

bind pause_rx_timer pause_rx_timer_chk #(.QW(QW)) u_chk (
  .clk(clk), .rst_n(rst_n), .man_en(man_en), .neg_en(neg_en),
  .slot_tick(slot_tick), .stat_rd(stat_rd), .pause_hold(pause_hold),
  .stat_rcvd(stat_rcvd), .frame_hit(frame_hit), .pause_abort(pause_abort),
  .frame_quanta(frame_quanta), .pause_count(pause_count)
);

// File: tb/pause_rx_timer_test.sv
module pause_rx_timer_test;
  logic clk = 1'b0;
  logic rst_n;
  logic rx_valid, rx_sof, rx_eof, rx_err, sta_match, pat_match;
  logic [7:0] rx_data;
  logic slot_tick, man_en, neg_en, mcast_qual, da_qual, stat_rd;
  logic pause_hold, stat_active, stat_rcvd;

  int checks = 0;
  int fails  = 0;

  localparam logic [47:0] MC  = 48'h0180C2000001;
  localparam logic [47:0] UNI = 48'h00AA55123456;

  always #10 clk = ~clk;

  pause_rx_timer uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err),
    .sta_match(sta_match), .pat_match(pat_match), .slot_tick(slot_tick),
    .man_en(man_en), .neg_en(neg_en), .mcast_qual(mcast_qual),
    .da_qual(da_qual), .stat_rd(stat_rd), .pause_hold(pause_hold),
    .stat_active(stat_active), .stat_rcvd(stat_rcvd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [47:0] da, input logic [15:0] typ,
                            input logic [15:0] opc, input logic [15:0] q,
                            input bit err, input bit sm, input bit pm,
                            input int pad, input bit side);
    int last;
    logic [7:0] b;
    last = 17 + pad;
    for (int i = 0; i <= last; i++) begin
      if (i < 6)       b = da[8*(5-i) +: 8];
      else if (i < 12) b = 8'h02 + 8'(i);
      else if (i == 12) b = typ[15:8];
      else if (i == 13) b = typ[7:0];
      else if (i == 14) b = opc[15:8];
      else if (i == 15) b = opc[7:0];
      else if (i == 16) b = q[15:8];
      else if (i == 17) b = q[7:0];
      else              b = 8'h00;
      @(negedge clk);
      rx_valid  = 1'b1;
      rx_data   = b;
      rx_sof    = (i == 0);
      rx_eof    = (i == last);
      rx_err    = err && (i == last);
      sta_match = sm;
      pat_match = pm;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
    sta_match = 1'b0; pat_match = 1'b0;
    if (side) begin
      slot_tick = 1'b1;
      stat_rd   = 1'b1;
    end
    @(negedge clk);
    slot_tick = 1'b0;
    stat_rd   = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slot_tick = 1'b1;
      @(negedge clk); slot_tick = 1'b0;
    end
  endtask

  task automatic read_status();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 hold after reset", pause_hold, 1'b0);
    check("R11 active after reset", stat_active, 1'b0);
    check("R11 rcvd after reset", stat_rcvd, 1'b0);
  endtask

  task automatic t_mcast_count();
    man_en = 1; neg_en = 0; mcast_qual = 1; da_qual = 0;
    send_frame(MC, 16'h8808, 16'h0001, 16'h0003, 0, 0, 0, 4, 0);
    check("R3 R5 hold after multicast pause", pause_hold, 1'b1);
    check("R5 active bit", stat_active, 1'b1);
    check("R7 rcvd set", stat_rcvd, 1'b1);
    ticks(2);
    check("R6 hold after 2 of 3 ticks", pause_hold, 1'b1);
    ticks(1);
    check("R6 hold after 3 of 3 ticks", pause_hold, 1'b0);
    ticks(1);
    check("R6 tick at zero has no effect", pause_hold, 1'b0);
  endtask

  task automatic t_clear_on_read();
    read_status();
    check("R7 rcvd cleared by read", stat_rcvd, 1'b0);
  endtask

  task automatic t_negotiated_da();
    man_en = 0; neg_en = 1; mcast_qual = 0; da_qual = 1;
    send_frame(UNI, 16'h8808, 16'h0001, 16'h0100, 0, 1, 0, 0, 0);
    check("R1 R4 negotiated enable, station match", pause_hold, 1'b1);
    send_frame(UNI, 16'h8808, 16'h0001, 16'h0000, 0, 1, 0, 0, 0);
    check("R9 zero quanta ends pause", pause_hold, 1'b0);
    read_status();
  endtask

  task automatic t_disabled();
    man_en = 0; neg_en = 0; mcast_qual = 1; da_qual = 1;
    send_frame(MC, 16'h8808, 16'h0001, 16'h0010, 0, 1, 1, 0, 0);
    check("R1 disabled frame: hold", pause_hold, 1'b0);
    check("R1 disabled frame: rcvd", stat_rcvd, 1'b0);
  endtask

  task automatic t_bad_frames();
    man_en = 1; neg_en = 0; mcast_qual = 1; da_qual = 0;
    send_frame(MC, 16'h0800, 16'h0001, 16'h0010, 0, 0, 0, 0, 0);
    check("R8 wrong type ignored", pause_hold, 1'b0);
    send_frame(MC, 16'h8808, 16'h0002, 16'h0010, 0, 0, 0, 0, 0);
    check("R8 wrong opcode ignored", pause_hold, 1'b0);
    send_frame(MC, 16'h8808, 16'h0001, 16'h0010, 1, 0, 0, 2, 0);
    check("R8 errored frame ignored", pause_hold, 1'b0);
    check("R8 no rcvd for bad frames", stat_rcvd, 1'b0);
    send_frame(UNI, 16'h8808, 16'h0001, 16'h0010, 0, 1, 1, 0, 0);
    check("R3 unicast DA with only multicast qual", pause_hold, 1'b0);
  endtask

  task automatic t_quals_off_and_pattern();
    mcast_qual = 0; da_qual = 0;
    send_frame(MC, 16'h8808, 16'h0001, 16'h0010, 0, 1, 1, 0, 0);
    check("R3 no qualification selected", pause_hold, 1'b0);
    da_qual = 1;
    send_frame(UNI, 16'h8808, 16'h0001, 16'h0020, 0, 0, 1, 0, 0);
    check("R4 pattern match qualifies", pause_hold, 1'b1);
    send_frame(UNI, 16'h8808, 16'h0001, 16'h0001, 0, 0, 1, 0, 0);
    ticks(1);
    check("R9 reload shortened to one tick", pause_hold, 1'b0);
    read_status();
  endtask

  task automatic t_abort();
    man_en = 1; neg_en = 0; mcast_qual = 1; da_qual = 0;
    send_frame(MC, 16'h8808, 16'h0001, 16'h0064, 0, 0, 0, 0, 0);
    check("R2 interval running before abort", pause_hold, 1'b1);
    @(negedge clk); man_en = 0;
    @(negedge clk);
    check("R2 clearing manual enable aborts", pause_hold, 1'b0);
    man_en = 1;
    read_status();
  endtask

  task automatic t_same_cycle();
    man_en = 1; mcast_qual = 1;
    send_frame(MC, 16'h8808, 16'h0001, 16'h0002, 0, 0, 0, 0, 1);
    check("R7 set wins over same-cycle read", stat_rcvd, 1'b1);
    ticks(1);
    check("R10 load beats tick: 1 of 2 ticks", pause_hold, 1'b1);
    ticks(1);
    check("R10 load beats tick: 2 of 2 ticks", pause_hold, 1'b0);
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; rx_valid = 0; rx_data = 0; rx_sof = 0; rx_eof = 0; rx_err = 0;
    sta_match = 0; pat_match = 0; slot_tick = 0; man_en = 0; neg_en = 0;
    mcast_qual = 0; da_qual = 0; stat_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mcast_count();
    t_clear_on_read();
    t_negotiated_da();
    t_disabled();
    t_bad_frames();
    t_quals_off_and_pattern();
    t_abort();
    t_same_cycle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule